// File: doc/BRIEF.md
# Exclusive Access Monitor Unit

This unit keeps the local reservation that one processing element needs for load-exclusive and store-exclusive operations. A load-exclusive request carries an address, a two-bit size code and an optional pair flag. When the access is naturally aligned, the unit arms a reservation over the reservation granule that holds the address, issues a read of the 16-byte memory line and, one cycle later, returns the loaded register values zero-extended to 64 bits.

A store-exclusive request also carries one or two register values, the big-endian flag for pair packing, and the index of the register that receives the status. The unit checks the reservation. If the check passes and the address is aligned, it writes memory with byte strobes and reports status 0. If the check fails, it does not write and reports status 1. If the check passes but the address is misaligned, it raises an alignment fault and writes back nothing. Every store attempt, an explicit clear and reset all drop the reservation.

An acquire/release flag on the request is passed on with the memory request as the ordered access type. Requests use a valid/ready handshake. The response is valid for exactly one cycle, one cycle after the request is accepted.

Top module: `excl_monitor_unit`

## Requirements
- R1: After reset no reservation is held, rsp_valid_o is 0 and req_ready_o is 1. A store-exclusive issued before any load-exclusive therefore reports status 1.
- R2: An access covers 2^size bytes, with size code 0..3 giving 1, 2, 4 or 8 bytes. The pair flag doubles the byte count only for size codes 2 and 3 and is ignored for codes 0 and 1. The access is aligned when the address is a multiple of its byte count.
- R3: An aligned load-exclusive issues a read (mem_req_o=1, mem_we_o=0) of the line at the address with its low 4 bits cleared. It arms the reservation with the address's granule (address bits above GRAN_LG) and the byte count. One cycle later it returns the bytes starting at address bit [3:0] of the line, little-endian and zero-extended, with rsp_rd_we_o bit 0 set.
- R4: A misaligned load-exclusive raises rsp_fault_o. It issues no memory request, writes no register and leaves the reservation as it was. A 64-bit pair load therefore needs 16-byte alignment.
- R5: A store-exclusive passes when a reservation is held, the store lies in the same granule, has the same byte count and ends inside that granule. A passing aligned store writes memory with one strobe bit per covered byte lane and reports status 0.
- R6: A store-exclusive that does not pass performs no memory request and reports status 1 with no fault. This holds even when the store is misaligned.
- R7: A store-exclusive that passes but is misaligned raises rsp_fault_o. It writes neither memory nor the status register.
- R8: Every accepted store-exclusive clears the reservation, whatever its outcome. clr_i clears it as well, and req_ready_o is 0 while clr_i is 1.
- R9: The status is written to register index req_rs_i as a 32-bit value whose bits 31..1 are zero. When that index equals the data register index, the original data value is still stored.
- R10: A pair store places the first register's element in the upper half of the stored data when req_big_endian_i is 1, and in the lower half when it is 0.
- R11: A 32-bit pair load gives the first destination the upper word when big-endian and the lower word otherwise. A 64-bit pair load gives the first destination the lower 8 bytes and the second destination the upper 8 bytes in both byte orders. rsp_rd_we_o bit 1 is set for pairs.
- R12: mem_ordered_o equals req_ordered_i on every cycle in which mem_req_o is 1.
- R13: rsp_valid_o is 1 in exactly the cycle that follows each accepted request and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Drop the reservation; stalls requests |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_store_i | input | 1 | 1 = store-exclusive, 0 = load-exclusive |
| req_pair_i | input | 1 | Pair access |
| req_size_i | input | 2 | Element size code |
| req_ordered_i | input | 1 | Acquire/release ordering flag |
| req_big_endian_i | input | 1 | Pair packing order |
| req_addr_i | input | AW | Byte address |
| req_rt_i | input | RIDX_W | First data register index |
| req_rt2_i | input | RIDX_W | Second data register index |
| req_rs_i | input | RIDX_W | Status register index |
| req_wdata_a_i | input | 64 | First register value |
| req_wdata_b_i | input | 64 | Second register value |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write |
| mem_ordered_o | output | 1 | Ordered access type |
| mem_addr_o | output | AW | Line address (low 4 bits zero) |
| mem_be_o | output | 16 | Byte lane strobes |
| mem_wdata_o | output | 128 | Write line data |
| mem_rdata_i | input | 128 | Read line data, one cycle after the read |
| rsp_valid_o | output | 1 | Response valid |
| rsp_fault_o | output | 1 | Alignment fault |
| rsp_status_we_o | output | 1 | Status write enable |
| rsp_status_idx_o | output | RIDX_W | Status register index |
| rsp_status_o | output | 32 | Status value |
| rsp_rd_we_o | output | 2 | Load destination write enables |
| rsp_rd_idx0_o | output | RIDX_W | First destination index |
| rsp_rd_idx1_o | output | RIDX_W | Second destination index |
| rsp_rd_data0_o | output | 64 | First destination value |
| rsp_rd_data1_o | output | 64 | Second destination value |

## Verification
The assertions check on every cycle that a response follows each accepted request and only such a request, and that a fault suppresses all write-back. They also check that a memory write happens only while a reservation is armed, that a store or a clear always leaves the reservation empty, and that the status upper bits are zero. Only the bench scenarios show the functional outcomes: which address and size combinations pass, the exact strobe and lane placement, both pair packing orders, and that a faulted load leaves the reservation intact. The bench shows these by following the request with a later store or load.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
   localparam int LINE_LG    = 4;
   localparam int LINE_BYTES = 1 << LINE_LG;
   localparam int LINE_W     = 8 * LINE_BYTES;
   localparam int REG_W      = 64;
   localparam int STATUS_W   = 32;

   typedef struct packed {
      logic [2:0] lg;
      logic [4:0] nbytes;
      logic       pair;
      logic       aligned;
   } access_shape_t;
endpackage

// File: rtl/excl_size_decode.sv
module excl_size_decode
   import excl_mon_pkg::*;
(
   input  logic [1:0]         size_i,
   input  logic               pair_i,
   input  logic [LINE_LG-1:0] off_i,
   output access_shape_t      shape_o
);
   logic       eff_pair;
   logic [2:0] lg;
   logic [LINE_LG-1:0] low_mask;

   always_comb begin
      eff_pair = pair_i & size_i[1];
      lg       = {1'b0, size_i} + {2'b00, eff_pair};
      low_mask = LINE_LG'((5'd1 << lg) - 5'd1);
      shape_o.lg      = lg;
      shape_o.nbytes  = 5'd1 << lg;
      shape_o.pair    = eff_pair;
      shape_o.aligned = ((off_i & low_mask) == '0);
   end
endmodule

// File: rtl/excl_resv_tracker.sv
module excl_resv_tracker #(
   parameter int AW      = 32,
   parameter int GRAN_LG = 4
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          clr_i,
   input  logic          set_i,
   input  logic          drop_i,
   input  logic [AW-1:0] addr_i,
   input  logic [2:0]    lg_i,
   input  logic [4:0]    nbytes_i,
   output logic          resv_valid_o,
   output logic          pass_o
);
   localparam int GW         = AW - GRAN_LG;
   localparam int OW         = GRAN_LG + 1;
   localparam int GRAN_BYTES = 1 << GRAN_LG;

   logic          valid_q;
   logic [GW-1:0] gran_q;
   logic [2:0]    lg_q;
   logic [OW-1:0] end_off;
   logic          fits;

   always_comb begin
      end_off = OW'(addr_i[GRAN_LG-1:0]) + OW'(nbytes_i);
      fits    = end_off <= OW'(GRAN_BYTES);
      pass_o  = valid_q && (addr_i[AW-1:GRAN_LG] == gran_q) && (lg_i == lg_q) && fits;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_q <= 1'b0;
         gran_q  <= '0;
         lg_q    <= '0;
      end else if (clr_i || drop_i) begin
         valid_q <= 1'b0;
      end else if (set_i) begin
         valid_q <= 1'b1;
         gran_q  <= addr_i[AW-1:GRAN_LG];
         lg_q    <= lg_i;
      end
   end

   assign resv_valid_o = valid_q;

   a_r8_drop_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i || drop_i) |=> !resv_valid_o);
   a_r3_set_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i && !clr_i && !drop_i) |=> resv_valid_o);
   a_r5_pass_needs_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pass_o |-> valid_q);
endmodule

// File: rtl/excl_lane_pack.sv
module excl_lane_pack
   import excl_mon_pkg::*;
(
   input  logic               wide_i,
   input  logic               pair_i,
   input  logic               big_endian_i,
   input  logic [REG_W-1:0]   data_a_i,
   input  logic [REG_W-1:0]   data_b_i,
   input  logic [LINE_LG-1:0] off_i,
   input  logic [4:0]         nbytes_i,
   output logic [LINE_W-1:0]  wdata_o,
   output logic [LINE_BYTES-1:0] be_o
);
   logic [LINE_W-1:0]     payload;
   logic [LINE_W-1:0]     shifted;
   logic [LINE_BYTES:0]   span;

   always_comb begin
      if (!pair_i) begin
         payload = {{(LINE_W-REG_W){1'b0}}, data_a_i};
      end else if (!wide_i) begin
         payload = big_endian_i
            ? {{(LINE_W-REG_W){1'b0}}, data_a_i[31:0], data_b_i[31:0]}
            : {{(LINE_W-REG_W){1'b0}}, data_b_i[31:0], data_a_i[31:0]};
      end else begin
         payload = big_endian_i ? {data_a_i, data_b_i} : {data_b_i, data_a_i};
      end
      shifted = payload << {off_i, 3'b000};
      span    = ((LINE_BYTES+1)'(1) << nbytes_i) - (LINE_BYTES+1)'(1);
      be_o    = span[LINE_BYTES-1:0] << off_i;
   end

   for (genvar k = 0; k < LINE_BYTES; k++) begin : g_lane
      assign wdata_o[8*k +: 8] = be_o[k] ? shifted[8*k +: 8] : 8'h00;
   end
endmodule

// File: rtl/excl_lane_unpack.sv
module excl_lane_unpack
   import excl_mon_pkg::*;
(
   input  logic [LINE_W-1:0]  line_i,
   input  logic [LINE_LG-1:0] off_i,
   input  logic [1:0]         size_i,
   input  logic               pair_i,
   input  logic               big_endian_i,
   output logic [REG_W-1:0]   data0_o,
   output logic [REG_W-1:0]   data1_o
);
   logic [LINE_W-1:0] sh;

   always_comb begin
      sh      = line_i >> {off_i, 3'b000};
      data0_o = '0;
      data1_o = '0;
      if (!pair_i) begin
         unique case (size_i)
            2'd0:    data0_o = {56'b0, sh[7:0]};
            2'd1:    data0_o = {48'b0, sh[15:0]};
            2'd2:    data0_o = {32'b0, sh[31:0]};
            default: data0_o = sh[63:0];
         endcase
      end else if (!size_i[0]) begin
         data0_o = {32'b0, big_endian_i ? sh[63:32] : sh[31:0]};
         data1_o = {32'b0, big_endian_i ? sh[31:0]  : sh[63:32]};
      end else begin
         data0_o = sh[63:0];
         data1_o = sh[127:64];
      end
   end
endmodule

// File: rtl/excl_monitor_unit.sv
module excl_monitor_unit
   import excl_mon_pkg::*;
#(
   parameter int AW      = 32,
   parameter int GRAN_LG = 4,
   parameter int RIDX_W  = 5
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  clr_i,
   input  logic                  req_valid_i,
   output logic                  req_ready_o,
   input  logic                  req_store_i,
   input  logic                  req_pair_i,
   input  logic [1:0]            req_size_i,
   input  logic                  req_ordered_i,
   input  logic                  req_big_endian_i,
   input  logic [AW-1:0]         req_addr_i,
   input  logic [RIDX_W-1:0]     req_rt_i,
   input  logic [RIDX_W-1:0]     req_rt2_i,
   input  logic [RIDX_W-1:0]     req_rs_i,
   input  logic [63:0]           req_wdata_a_i,
   input  logic [63:0]           req_wdata_b_i,
   output logic                  mem_req_o,
   output logic                  mem_we_o,
   output logic                  mem_ordered_o,
   output logic [AW-1:0]         mem_addr_o,
   output logic [15:0]           mem_be_o,
   output logic [127:0]          mem_wdata_o,
   input  logic [127:0]          mem_rdata_i,
   output logic                  rsp_valid_o,
   output logic                  rsp_fault_o,
   output logic                  rsp_status_we_o,
   output logic [RIDX_W-1:0]     rsp_status_idx_o,
   output logic [31:0]           rsp_status_o,
   output logic [1:0]            rsp_rd_we_o,
   output logic [RIDX_W-1:0]     rsp_rd_idx0_o,
   output logic [RIDX_W-1:0]     rsp_rd_idx1_o,
   output logic [63:0]           rsp_rd_data0_o,
   output logic [63:0]           rsp_rd_data1_o
);
   if (GRAN_LG < LINE_LG || GRAN_LG >= AW) begin : g_bad_gran
      $error("excl_monitor_unit: GRAN_LG must lie in [LINE_LG, AW-1]");
   end
   if (RIDX_W < 1) begin : g_bad_ridx
      $error("excl_monitor_unit: RIDX_W must be positive");
   end

   access_shape_t shape;
   logic accept, is_ld, is_st;
   logic pass, resv_valid;
   logic ld_fault, st_fault, st_write, ld_issue;
   logic [LINE_W-1:0]     packed_data;
   logic [LINE_BYTES-1:0] lane_be;

   // response pipeline state
   logic                 v_q, store_q, fault_q, fail_q, pair_q, be_end_q;
   logic [1:0]           size_q;
   logic [LINE_LG-1:0]   off_q;
   logic [RIDX_W-1:0]    rs_q, rt_q, rt2_q;
   logic [REG_W-1:0]     u0, u1;

   excl_size_decode u_decode (
      .size_i  (req_size_i),
      .pair_i  (req_pair_i),
      .off_i   (req_addr_i[LINE_LG-1:0]),
      .shape_o (shape)
   );

   assign req_ready_o = !clr_i;
   assign accept      = req_valid_i && !clr_i;
   assign is_ld       = accept && !req_store_i;
   assign is_st       = accept &&  req_store_i;
   assign ld_issue    = is_ld && shape.aligned;
   assign ld_fault    = is_ld && !shape.aligned;
   assign st_write    = is_st && pass && shape.aligned;
   assign st_fault    = is_st && pass && !shape.aligned;

   excl_resv_tracker #(.AW(AW), .GRAN_LG(GRAN_LG)) u_resv (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .clr_i        (clr_i),
      .set_i        (ld_issue),
      .drop_i       (is_st),
      .addr_i       (req_addr_i),
      .lg_i         (shape.lg),
      .nbytes_i     (shape.nbytes),
      .resv_valid_o (resv_valid),
      .pass_o       (pass)
   );

   excl_lane_pack u_pack (
      .wide_i       (req_size_i[0]),
      .pair_i       (shape.pair),
      .big_endian_i (req_big_endian_i),
      .data_a_i     (req_wdata_a_i),
      .data_b_i     (req_wdata_b_i),
      .off_i        (req_addr_i[LINE_LG-1:0]),
      .nbytes_i     (shape.nbytes),
      .wdata_o      (packed_data),
      .be_o         (lane_be)
   );

   always_comb begin
      mem_req_o     = ld_issue || st_write;
      mem_we_o      = st_write;
      mem_ordered_o = mem_req_o && req_ordered_i;
      mem_addr_o    = {req_addr_i[AW-1:LINE_LG], {LINE_LG{1'b0}}};
      mem_be_o      = mem_req_o ? lane_be : '0;
      mem_wdata_o   = st_write ? packed_data : '0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         v_q      <= 1'b0;
         store_q  <= 1'b0;
         fault_q  <= 1'b0;
         fail_q   <= 1'b0;
         pair_q   <= 1'b0;
         be_end_q <= 1'b0;
         size_q   <= '0;
         off_q    <= '0;
         rs_q     <= '0;
         rt_q     <= '0;
         rt2_q    <= '0;
      end else begin
         v_q <= accept;
         if (accept) begin
            store_q  <= req_store_i;
            fault_q  <= ld_fault || st_fault;
            fail_q   <= !pass;
            pair_q   <= shape.pair;
            be_end_q <= req_big_endian_i;
            size_q   <= req_size_i;
            off_q    <= req_addr_i[LINE_LG-1:0];
            rs_q     <= req_rs_i;
            rt_q     <= req_rt_i;
            rt2_q    <= req_rt2_i;
         end
      end
   end

   excl_lane_unpack u_unpack (
      .line_i       (mem_rdata_i),
      .off_i        (off_q),
      .size_i       (size_q),
      .pair_i       (pair_q),
      .big_endian_i (be_end_q),
      .data0_o      (u0),
      .data1_o      (u1)
   );

   always_comb begin
      rsp_valid_o      = v_q;
      rsp_fault_o      = v_q && fault_q;
      rsp_status_we_o  = v_q && store_q && !fault_q;
      rsp_status_idx_o = rs_q;
      rsp_status_o     = {{(STATUS_W-1){1'b0}}, fail_q};
      rsp_rd_we_o[0]   = v_q && !store_q && !fault_q;
      rsp_rd_we_o[1]   = v_q && !store_q && !fault_q && pair_q;
      rsp_rd_idx0_o    = rt_q;
      rsp_rd_idx1_o    = rt2_q;
      rsp_rd_data0_o   = rsp_rd_we_o[0] ? u0 : '0;
      rsp_rd_data1_o   = rsp_rd_we_o[1] ? u1 : '0;
   end

   a_r13_rsp_follows_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_ready_o) |=> rsp_valid_o);
   a_r13_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(req_valid_i && req_ready_o) |=> !rsp_valid_o);
   a_r7_fault_blocks_writeback: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_fault_o |-> (!rsp_status_we_o && rsp_rd_we_o == 2'b00));
   a_r5_write_needs_resv: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_req_o && mem_we_o) |-> resv_valid);
   a_r9_status_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_status_we_o |-> (rsp_status_o[31:1] == '0));
   a_r3_strobe_present: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o |-> (mem_be_o != '0));
   a_r8_stall_on_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |-> !mem_req_o);
endmodule

// File: tb/excl_monitor_unit_tb.sv
module excl_monitor_unit_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic         clr, req_valid, req_ready, req_store, req_pair, req_ord, req_be;
   logic [1:0]   req_size;
   logic [31:0]  req_addr;
   logic [4:0]   req_rt, req_rt2, req_rs;
   logic [63:0]  wa, wb;
   logic         mem_req, mem_we, mem_ord;
   logic [31:0]  mem_addr;
   logic [15:0]  mem_be;
   logic [127:0] mem_wdata, mem_rdata;
   logic         rsp_valid, rsp_fault, rsp_swe;
   logic [4:0]   rsp_sidx, rsp_i0, rsp_i1;
   logic [31:0]  rsp_status;
   logic [1:0]   rsp_rwe;
   logic [63:0]  rsp_d0, rsp_d1;

   excl_monitor_unit u_dut (
      .clk_i(clk), .rst_ni(rst_n), .clr_i(clr),
      .req_valid_i(req_valid), .req_ready_o(req_ready), .req_store_i(req_store),
      .req_pair_i(req_pair), .req_size_i(req_size), .req_ordered_i(req_ord),
      .req_big_endian_i(req_be), .req_addr_i(req_addr), .req_rt_i(req_rt),
      .req_rt2_i(req_rt2), .req_rs_i(req_rs), .req_wdata_a_i(wa), .req_wdata_b_i(wb),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_ordered_o(mem_ord),
      .mem_addr_o(mem_addr), .mem_be_o(mem_be), .mem_wdata_o(mem_wdata),
      .mem_rdata_i(mem_rdata),
      .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_status_we_o(rsp_swe),
      .rsp_status_idx_o(rsp_sidx), .rsp_status_o(rsp_status), .rsp_rd_we_o(rsp_rwe),
      .rsp_rd_idx0_o(rsp_i0), .rsp_rd_idx1_o(rsp_i1),
      .rsp_rd_data0_o(rsp_d0), .rsp_rd_data1_o(rsp_d1)
   );

   int tests = 0;
   int fails = 0;

   // Behavioural memory: 256 bytes, 16-byte lines, read data one cycle later
   logic [7:0] mem [0:255];
   always @(posedge clk) begin
      if (mem_req && mem_we) begin
         for (int k = 0; k < 16; k++)
            if (mem_be[k]) mem[(mem_addr[7:0] + k) & 255] <= mem_wdata[8*k +: 8];
      end
      if (mem_req && !mem_we) begin
         for (int k = 0; k < 16; k++)
            mem_rdata[8*k +: 8] <= mem[(mem_addr[7:0] + k) & 255];
      end
   end

   // Reference reservation state
   bit rv = 0;
   int rgran = 0;
   int rlg = 0;

   task automatic chk(input string req, input string what, input logic [127:0] act,
                      input logic [127:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   // R13: per-clock comparison of the response strobe with accepted requests
   logic acc_d = 1'b0;
   always @(posedge clk) acc_d <= rst_n && req_valid && req_ready;
   always @(negedge clk) if (rst_n) chk("R13", "rsp_valid per cycle", 128'(rsp_valid), 128'(acc_d));

   task automatic xact(input bit st, input bit pr, input logic [1:0] sz, input bit ord,
                       input bit bend, input logic [31:0] addr, input logic [4:0] rt,
                       input logic [4:0] rt2, input logic [4:0] rs,
                       input logic [63:0] a, input logic [63:0] b, input string tag);
      bit pe, aligned, pass, fault, wr, issue;
      int lg, nb, off;
      logic [127:0] p, ew, ld;
      logic [15:0]  ebe;
      logic [63:0]  e0, e1;
      pe = pr && sz >= 2;
      lg = int'(sz) + (pe ? 1 : 0);
      nb = 1 << lg;
      off = int'(addr[3:0]);
      aligned = (addr % nb) == 0;
      pass = rv && (int'(addr >> 4) == rgran) && (lg == rlg) && ((off + nb) <= 16);
      fault = st ? (pass && !aligned) : !aligned;
      wr = st && pass && aligned;
      issue = st ? wr : aligned;
      p = '0;
      if (!pe) p[63:0] = a;
      else if (sz == 2) begin
         p[31:0]  = bend ? b[31:0] : a[31:0];
         p[63:32] = bend ? a[31:0] : b[31:0];
      end else begin
         p[63:0]   = bend ? b : a;
         p[127:64] = bend ? a : b;
      end
      ew = '0; ebe = '0;
      for (int i = 0; i < nb; i++) begin
         if (off + i < 16) begin
            ebe[off+i] = 1'b1;
            ew[8*(off+i) +: 8] = p[8*i +: 8];
         end
      end
      req_store = st; req_pair = pr; req_size = sz; req_ord = ord; req_be = bend;
      req_addr = addr; req_rt = rt; req_rt2 = rt2; req_rs = rs; wa = a; wb = b;
      req_valid = 1'b1;
      #1;
      chk(tag, "mem_req", 128'(mem_req), 128'(issue));
      chk(tag, "mem_we", 128'(mem_we), 128'(wr));
      if (issue) begin
         chk(tag, "mem_addr", 128'(mem_addr), 128'({addr[31:4], 4'b0}));
         chk(tag, "mem_be", 128'(mem_be), 128'(ebe));
         chk("R12", "mem_ordered", 128'(mem_ord), 128'(ord));
         if (wr) chk(tag, "mem_wdata", mem_wdata, ew);
      end
      ld = '0;
      for (int i = 0; i < nb; i++) ld[8*i +: 8] = mem[(addr[7:0] + i) & 255];
      @(posedge clk);
      if (!st && aligned) begin rv = 1; rgran = int'(addr >> 4); rlg = lg; end
      if (st) rv = 0;
      @(negedge clk);
      req_valid = 1'b0;
      chk(tag, "rsp_fault", 128'(rsp_fault), 128'(fault));
      chk(tag, "status_we", 128'(rsp_swe), 128'(st && !fault));
      if (st && !fault) begin
         chk(tag, "status", 128'(rsp_status), 128'(pass ? 32'd0 : 32'd1));
         chk("R9", "status idx", 128'(rsp_sidx), 128'(rs));
      end
      chk(tag, "rd_we", 128'(rsp_rwe), 128'(!st && !fault ? {pe, 1'b1} : 2'b00));
      if (!st && !fault) begin
         if (!pe) begin e0 = ld[63:0]; e1 = '0; end
         else if (sz == 2) begin
            e0 = {32'b0, bend ? ld[63:32] : ld[31:0]};
            e1 = {32'b0, bend ? ld[31:0] : ld[63:32]};
         end else begin e0 = ld[63:0]; e1 = ld[127:64]; end
         chk(tag, "rd_data0", 128'(rsp_d0), 128'(e0));
         chk(tag, "rd_idx0", 128'(rsp_i0), 128'(rt));
         if (pe) begin
            chk(tag, "rd_data1", 128'(rsp_d1), 128'(e1));
            chk(tag, "rd_idx1", 128'(rsp_i1), 128'(rt2));
         end
      end
   endtask

   task automatic do_clear();
      clr = 1'b1; req_valid = 1'b1; req_store = 1'b0; req_addr = 32'h0; req_size = 2'd0;
      #1;
      chk("R8", "ready low during clear", 128'(req_ready), 128'(0));
      chk("R8", "no mem during clear", 128'(mem_req), 128'(0));
      @(posedge clk); rv = 0;
      @(negedge clk);
      clr = 1'b0; req_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      clr = 0; req_valid = 0; req_store = 0; req_pair = 0; req_size = 0; req_ord = 0;
      req_be = 0; req_addr = 0; req_rt = 0; req_rt2 = 0; req_rs = 0; wa = 0; wb = 0;
      mem_rdata = '0;
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
      repeat (3) @(negedge clk);
      chk("R1", "rsp_valid in reset", 128'(rsp_valid), 128'(0));
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "ready after reset", 128'(req_ready), 128'(1));
      chk("R1", "no mem after reset", 128'(mem_req), 128'(0));
      // R1/R6: store with nothing reserved fails
      xact(1, 0, 2, 0, 0, 32'h10, 1, 2, 3, 64'hdead, 0, "R1");
      // R3: aligned word load, R5/R9: matching store with rs == rt
      xact(0, 0, 2, 1, 0, 32'h24, 4, 0, 0, 0, 0, "R3");
      xact(1, 0, 2, 1, 0, 32'h24, 3, 0, 3, 64'hcafef00d, 0, "R5");
      xact(0, 0, 2, 0, 0, 32'h24, 5, 0, 0, 0, 0, "R9");
      // R8: second store after a success fails
      xact(1, 0, 2, 0, 0, 32'h24, 3, 0, 6, 64'h1234, 0, "R8");
      // R4: misaligned load faults, reservation survives
      xact(0, 0, 1, 0, 0, 32'h30, 7, 0, 0, 0, 0, "R3");
      xact(0, 0, 1, 0, 0, 32'h33, 7, 0, 0, 0, 0, "R4");
      xact(1, 0, 1, 0, 0, 32'h30, 7, 0, 8, 64'hbeef, 0, "R4");
      // R6: size mismatch, granule mismatch
      xact(0, 0, 1, 0, 0, 32'h40, 1, 0, 0, 0, 0, "R3");
      xact(1, 0, 2, 0, 0, 32'h40, 1, 0, 2, 64'h5555, 0, "R6");
      xact(0, 0, 0, 0, 0, 32'h41, 1, 0, 0, 0, 0, "R3");
      xact(1, 0, 0, 0, 0, 32'h52, 1, 0, 2, 64'h66, 0, "R6");
      // R7: passing misaligned store faults, memory untouched
      xact(0, 0, 1, 0, 0, 32'h60, 1, 0, 0, 0, 0, "R3");
      xact(1, 0, 1, 0, 0, 32'h61, 1, 0, 2, 64'hffff, 0, "R7");
      xact(0, 0, 1, 0, 0, 32'h60, 1, 0, 0, 0, 0, "R7");
      // R6: misaligned failing store, no fault
      xact(1, 0, 2, 0, 0, 32'h6e, 1, 0, 2, 64'h77, 0, "R6");
      // R8: clear drops reservation
      xact(0, 0, 3, 0, 0, 32'h70, 1, 0, 0, 0, 0, "R3");
      do_clear();
      xact(1, 0, 3, 0, 0, 32'h70, 1, 0, 2, 64'h88, 0, "R8");
      // R10/R11: 32-bit pairs, both orders
      xact(0, 1, 2, 0, 0, 32'h80, 1, 2, 0, 0, 0, "R11");
      xact(1, 1, 2, 1, 0, 32'h80, 1, 2, 3, 64'h11223344, 64'h55667788, "R10");
      xact(0, 1, 2, 0, 0, 32'h80, 1, 2, 0, 0, 0, "R11");
      xact(0, 1, 2, 0, 1, 32'h80, 1, 2, 0, 0, 0, "R11");
      xact(1, 1, 2, 0, 1, 32'h80, 1, 2, 3, 64'haabbccdd, 64'h01020304, "R10");
      xact(0, 1, 2, 0, 0, 32'h80, 1, 2, 0, 0, 0, "R10");
      // R10/R11: 64-bit pairs
      xact(0, 1, 3, 1, 1, 32'h90, 4, 5, 0, 0, 0, "R11");
      xact(1, 1, 3, 1, 1, 32'h90, 4, 5, 6, 64'h0102030405060708, 64'h1112131415161718, "R10");
      xact(0, 1, 3, 0, 0, 32'h90, 4, 5, 0, 0, 0, "R11");
      // R4: 64-bit pair needs 16-byte alignment
      xact(0, 1, 3, 0, 0, 32'ha8, 4, 5, 0, 0, 0, "R4");
      // R2: pair ignored for byte size
      xact(0, 1, 0, 0, 0, 32'hb3, 9, 10, 0, 0, 0, "R2");
      xact(1, 1, 0, 1, 0, 32'hb3, 9, 10, 11, 64'h5a, 64'ha5, "R2");
      xact(0, 0, 0, 0, 0, 32'hb3, 9, 0, 0, 0, 0, "R2");
      repeat (2) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule